// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor core. It keeps a record, per interrupt line, of whether the line is enabled, whether a request is waiting and what urgency level it has. From that record it offers the core one exception at a time, as an exception number with a valid flag. Software reaches the record through a small word-wide register bus. Enable and waiting state each have a set address and a clear address. Urgency levels are packed four to a word.

The core answers an offered exception with a one-cycle acknowledge. This moves that interrupt from waiting to in-service. A completion pulse carrying an exception number ends the service. A single non-maskable line is served ahead of everything else. It ignores the enables, the global disable and the core's running priority. Ordinary interrupts are offered only when their level is strictly more urgent than the priority the core is running at. A global disable state, driven by two control inputs, holds back every ordinary interrupt.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every enable, waiting and priority field reads 0, the global disable is off and `req_valid` is 0.
- R2: A write to 0xE000E100 enables each line whose data bit is 1. A write to 0xE000E180 disables each line whose data bit is 1. Data bits at 0 change nothing, and bits at or above `NUM_IRQ` are dropped. A read of either address returns the enable mask in bits [NUM_IRQ-1:0] and 0 above. A waiting but disabled line is never offered.
- R3: Writes to 0xE000E200 and 0xE000E280 set and clear waiting bits with the same write-one rule. A read of either address returns the waiting mask.
- R4: Priority word k sits at 0xE000E400 + 4k, for k from 0 to 7. Line n uses byte n mod 4 of word n/4, and its 2-bit level sits in bits [7:6] of that byte. All other bits, and the fields of lines that do not exist, read 0 and ignore writes.
- R5: A line that is high at a clock edge sets its waiting bit at that edge. The bit stays set after the line drops, until it is cleared. While the line stays high, a clear write cannot remove the bit.
- R6: Among lines that are enabled, waiting and not in service, the one with the numerically lowest level wins. A tie goes to the lower line number. The offered number is 16 + line.
- R7: An ordinary interrupt is offered only when its level is strictly below `exec_prio`. The value 4 means that no priority is running.
- R8: A pulse on `mask_set_in` turns the global disable on, and a pulse on `mask_clr_in` turns it off. If both pulse together, the disable turns on. While the disable is on, no ordinary interrupt is offered.
- R9: A high `nmi_in` makes exception 2 waiting. While it waits and is not in service, it is offered ahead of any ordinary interrupt, whatever the enables, the global disable or `exec_prio` say.
- R10: `ack_in` while `req_valid` is high clears the waiting bit of the offered exception and marks it in service. An in-service exception is not offered again, even if it becomes waiting again.
- R11: `done_in` with `done_num` ends service of that exception (2 for the non-maskable line, 16 + n for line n), so it can be offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 32 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_in | input | NUM_IRQ | Active-high interrupt lines |
| nmi_in | input | 1 | Non-maskable request line |
| mask_set_in | input | 1 | Turn the global disable on |
| mask_clr_in | input | 1 | Turn the global disable off |
| exec_prio | input | PRIO_W+1 | Running priority of the core; 2**PRIO_W means none |
| req_valid | output | 1 | An exception is offered |
| req_num | output | 6 | Offered exception number |
| ack_in | input | 1 | Core takes the offered exception |
| done_in | input | 1 | Core finished an exception |
| done_num | input | 6 | Number of the finished exception |

## Verification
The bench builds the block with its defaults: 16 lines and 2-bit levels. With these values the four implemented priority words and the four empty ones can both be reached, so the bench can check that fields beyond the last line read 0. The two-bit width makes every level comparison against `exec_prio` reachable, including the no-priority value 4 and the strict-inequality edge at equal levels. Ties, masking, the non-maskable line beating a waiting interrupt, and a line re-pending while it is in service are all driven on purpose.

// File: rtl/vic_pkg.sv
// Package: shared constants, register selector type and address decode for
// the vectored interrupt controller. Assumes word-aligned 32-bit addresses.
package vic_pkg;

    localparam int          EXC_W       = 6;
    localparam logic [31:0] A_EN_SET    = 32'hE000_E100;
    localparam logic [31:0] A_EN_CLR    = 32'hE000_E180;
    localparam logic [31:0] A_PEND_SET  = 32'hE000_E200;
    localparam logic [31:0] A_PEND_CLR  = 32'hE000_E280;
    localparam logic [31:0] A_PRIO_BASE = 32'hE000_E400;
    localparam logic [EXC_W-1:0] EXC_NMI      = 6'd2;
    localparam logic [EXC_W-1:0] EXC_IRQ_BASE = 6'd16;

    typedef enum logic [2:0] {
        RS_NONE, RS_EN_SET, RS_EN_CLR, RS_PEND_SET, RS_PEND_CLR, RS_PRIO
    } reg_sel_e;

    // Map a bus address onto one of the register groups.
    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00)                 s = RS_NONE;
        else if (a == A_EN_SET)              s = RS_EN_SET;
        else if (a == A_EN_CLR)              s = RS_EN_CLR;
        else if (a == A_PEND_SET)            s = RS_PEND_SET;
        else if (a == A_PEND_CLR)            s = RS_PEND_CLR;
        else if (a[31:5] == A_PRIO_BASE[31:5]) s = RS_PRIO;
        else                                 s = RS_NONE;
        return s;
    endfunction

endpackage

// File: rtl/vic_regs.sv
// Module: software-visible state. Holds enables, waiting bits and priority
// levels, decodes bus writes and returns reads combinationally.
// Assumes single-cycle bus strobes and NUM_IRQ <= 32.
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int PRIO_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [31:0]               bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_IRQ-1:0]        irq_in,
    input  logic [NUM_IRQ-1:0]        ack_clr,
    output logic [NUM_IRQ-1:0]        en_o,
    output logic [NUM_IRQ-1:0]        pend_o,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_o
);
    localparam int FIELD_LSB = 8 - PRIO_W;

    reg_sel_e             sel;
    logic                 wr;
    logic [2:0]           word;
    logic [NUM_IRQ-1:0]   wmask;
    logic [NUM_IRQ-1:0]   en_q;
    logic [NUM_IRQ-1:0]   pend_q;
    logic [PRIO_W-1:0]    prio_q [NUM_IRQ];

    assign sel   = decode_addr(bus_addr);
    assign wr    = bus_sel && bus_we;
    assign word  = bus_addr[4:2];
    assign wmask = bus_wdata[NUM_IRQ-1:0];

    // Enable mask: write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr && sel == RS_EN_SET)     en_q <= en_q | wmask;
        else if (wr && sel == RS_EN_CLR)     en_q <= en_q & ~wmask;
    end

    // Waiting mask: lines and set writes win over clears and acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else pend_q <= (pend_q
                        & ~((wr && sel == RS_PEND_CLR) ? wmask : '0)
                        & ~ack_clr)
                       | ((wr && sel == RS_PEND_SET) ? wmask : '0)
                       | irq_in;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
        localparam int WI = g / 4;
        localparam int BI = g % 4;
        // Priority field: top bits of the byte lane owned by this line.
        always_ff @(posedge clk) begin
            if (!rst_n) prio_q[g] <= '0;
            else if (wr && sel == RS_PRIO && int'(word) == WI)
                prio_q[g] <= bus_wdata[BI*8+FIELD_LSB +: PRIO_W];
        end
        assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

    // Read mux: masks zero-extended, priority bytes rebuilt from fields.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            RS_EN_SET, RS_EN_CLR:     bus_rdata[NUM_IRQ-1:0] = en_q;
            RS_PEND_SET, RS_PEND_CLR: bus_rdata[NUM_IRQ-1:0] = pend_q;
            RS_PRIO: begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (int'(word) == i / 4)
                        bus_rdata[(i%4)*8+FIELD_LSB +: PRIO_W] = prio_q[i];
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;

    // R2
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == RS_EN_CLR) |=> ((en_q & $past(wmask)) == '0));

    // R5
    line_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((pend_q & $past(irq_in)) == $past(irq_in)));

endmodule

// File: rtl/vic_pick.sv
// Module: combinational winner search. Scans candidates from line 0 upward,
// replacing the best only on a strictly lower level, so ties keep the lower
// line number. Assumes NUM_IRQ >= 2.
module vic_pick #(
    parameter int NUM_IRQ = 16,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Linear scan keeping the most urgent candidate seen so far.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vic_core.sv
// Module: exception arbitration. Tracks in-service lines, the non-maskable
// request and the global disable. It gates the winner against the running
// priority and turns acknowledges into waiting-bit clears.
// Assumes ack_in and done_in are single-cycle pulses from the core.
module vic_core
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        en,
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    input  logic                      nmi_in,
    input  logic                      mask_set_in,
    input  logic                      mask_clr_in,
    input  logic [PRIO_W:0]           exec_prio,
    input  logic                      ack_in,
    input  logic                      done_in,
    input  logic [EXC_W-1:0]          done_num,
    output logic                      req_valid,
    output logic [EXC_W-1:0]          req_num,
    output logic [NUM_IRQ-1:0]        ack_clr
);
    logic                 mask_q;
    logic [NUM_IRQ-1:0]   act_q;
    logic                 nmi_pend_q;
    logic                 nmi_act_q;
    logic [NUM_IRQ-1:0]   cand;
    logic [NUM_IRQ-1:0]   done_clr;
    logic                 found;
    logic [IDX_W-1:0]     win_idx;
    logic [PRIO_W-1:0]    win_prio;
    logic                 irq_ok;
    logic                 nmi_req;
    logic                 take_nmi;
    logic                 take_irq;

    assign cand = en & pend & ~act_q & {NUM_IRQ{~mask_q}};

    vic_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
        .cand     (cand),
        .prio     (prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    assign irq_ok    = found && ({1'b0, win_prio} < exec_prio);
    assign nmi_req   = nmi_pend_q && !nmi_act_q;
    assign req_valid = nmi_req || irq_ok;
    assign req_num   = nmi_req ? EXC_NMI : (EXC_IRQ_BASE + EXC_W'(win_idx));
    assign take_nmi  = ack_in && nmi_req;
    assign take_irq  = ack_in && !nmi_req && irq_ok;

    // Decode acknowledge and completion into per-line vectors.
    always_comb begin
        ack_clr  = '0;
        done_clr = '0;
        if (take_irq) ack_clr[win_idx] = 1'b1;
        for (int i = 0; i < NUM_IRQ; i++)
            done_clr[i] = done_in && (done_num == EXC_IRQ_BASE + EXC_W'(i));
    end

    // Global disable: a set pulse wins over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= 1'b0;
        else if (mask_set_in) mask_q <= 1'b1;
        else if (mask_clr_in) mask_q <= 1'b0;
    end

    // In-service lines: set on acknowledge, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= (act_q & ~done_clr) | ack_clr;
    end

    // Non-maskable request and its in-service flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pend_q <= 1'b0;
            nmi_act_q  <= 1'b0;
        end else begin
            nmi_pend_q <= nmi_in || (nmi_pend_q && !take_nmi);
            nmi_act_q  <= (nmi_act_q && !(done_in && done_num == EXC_NMI)) || take_nmi;
        end
    end

    // R8
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !(req_valid && req_num != EXC_NMI));

    // R9
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !nmi_act_q && !ack_in) |=> (req_valid && req_num == EXC_NMI));

    // R7
    prio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_num != EXC_NMI)
            |-> ({1'b0, prio[win_idx*PRIO_W +: PRIO_W]} < exec_prio));

    // R10
    ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> act_q[$past(win_idx)]);

    // R10
    no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !(req_valid && req_num == $past(req_num)));

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the vectored interrupt controller. Joins the register
// state to the arbiter. Assumes a word-wide bus with one-cycle write strobes
// and combinational reads, and NUM_IRQ between 2 and 32.
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int PRIO_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [31:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic                 nmi_in,
    input  logic                 mask_set_in,
    input  logic                 mask_clr_in,
    input  logic [PRIO_W:0]      exec_prio,
    output logic                 req_valid,
    output logic [5:0]           req_num,
    input  logic                 ack_in,
    input  logic                 done_in,
    input  logic [5:0]           done_num
);
    logic [NUM_IRQ-1:0]        en;
    logic [NUM_IRQ-1:0]        pend;
    logic [NUM_IRQ*PRIO_W-1:0] prio;
    logic [NUM_IRQ-1:0]        ack_clr;

    vic_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .ack_clr   (ack_clr),
        .en_o      (en),
        .pend_o    (pend),
        .prio_o    (prio)
    );

    vic_core #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .pend        (pend),
        .prio        (prio),
        .nmi_in      (nmi_in),
        .mask_set_in (mask_set_in),
        .mask_clr_in (mask_clr_in),
        .exec_prio   (exec_prio),
        .ack_in      (ack_in),
        .done_in     (done_in),
        .done_num    (done_num),
        .req_valid   (req_valid),
        .req_num     (req_num),
        .ack_clr     (ack_clr)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !req_valid);

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

    localparam logic [31:0] ESET = 32'hE000_E100;
    localparam logic [31:0] ECLR = 32'hE000_E180;
    localparam logic [31:0] PSET = 32'hE000_E200;
    localparam logic [31:0] PCLR = 32'hE000_E280;
    localparam logic [31:0] PR0  = 32'hE000_E400;
    localparam logic [31:0] PR1  = 32'hE000_E404;
    localparam logic [31:0] PR3  = 32'hE000_E40C;
    localparam logic [31:0] PR5  = 32'hE000_E414;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, ESET, 32'h0000_0005, 4'd2},
        '{1'b0, ESET, 32'h0000_0005, 4'd2},   // R2 read via set address
        '{1'b0, ECLR, 32'h0000_0005, 4'd2},   // R2 read via clear address
        '{1'b1, ECLR, 32'h0000_0001, 4'd2},
        '{1'b0, ESET, 32'h0000_0004, 4'd2},
        '{1'b1, ECLR, 32'h0000_0000, 4'd2},
        '{1'b0, ECLR, 32'h0000_0004, 4'd2},   // R2 zero bits do nothing
        '{1'b1, ESET, 32'hFFFF_0000, 4'd2},
        '{1'b0, ESET, 32'h0000_0004, 4'd2},   // R2 absent lines dropped
        '{1'b1, PSET, 32'h0000_0300, 4'd3},
        '{1'b0, PSET, 32'h0000_0300, 4'd3},   // R3
        '{1'b1, PCLR, 32'h0000_0100, 4'd3},
        '{1'b0, PCLR, 32'h0000_0200, 4'd3},   // R3
        '{1'b1, PCLR, 32'h0000_0000, 4'd3},
        '{1'b0, PSET, 32'h0000_0200, 4'd3},   // R3 zero bits do nothing
        '{1'b1, PR0,  32'hFFFF_FFFF, 4'd4},
        '{1'b0, PR0,  32'hC0C0_C0C0, 4'd4},   // R4 only bits [7:6] stick
        '{1'b1, PR3,  32'h7F81_C13F, 4'd4},
        '{1'b0, PR3,  32'h4080_C000, 4'd4},   // R4 byte lanes
        '{1'b1, PR5,  32'hFFFF_FFFF, 4'd4},
        '{1'b0, PR5,  32'h0000_0000, 4'd4},   // R4 absent lines read 0
        '{1'b0, PR1,  32'h0000_0000, 4'd4},   // R4 untouched word
        '{1'b1, ECLR, 32'hFFFF_FFFF, 4'd2},
        '{1'b1, PCLR, 32'hFFFF_FFFF, 4'd3},
        '{1'b1, PR0,  32'h0000_0000, 4'd4},
        '{1'b1, PR3,  32'h0000_0000, 4'd4},
        '{1'b0, ESET, 32'h0000_0000, 4'd2},
        '{1'b0, PSET, 32'h0000_0000, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        nmi_in = 1'b0, mask_set_in = 1'b0, mask_clr_in = 1'b0;
    logic [2:0]  exec_prio = 3'd0;
    logic        req_valid;
    logic [5:0]  req_num;
    logic        ack_in = 1'b0, done_in = 1'b0;
    logic [5:0]  done_num = '0;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .nmi_in(nmi_in), .mask_set_in(mask_set_in),
        .mask_clr_in(mask_clr_in), .exec_prio(exec_prio),
        .req_valid(req_valid), .req_num(req_num), .ack_in(ack_in),
        .done_in(done_in), .done_num(done_num)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Offered exception packed as {valid, number}; 0 when nothing offered.
    task automatic check_req(input string tag, input logic [6:0] exp);
        @(negedge clk);
        #1 check(tag, req_valid ? {25'd0, 1'b1, req_num} : 32'd0, {25'd0, exp});
    endtask

    task automatic pulse_ctl(input logic ms, input logic mc, input logic ak,
                             input logic dn, input logic [5:0] num);
        @(negedge clk);
        mask_set_in = ms; mask_clr_in = mc; ack_in = ak; done_in = dn; done_num = num;
        @(negedge clk);
        mask_set_in = 1'b0; mask_clr_in = 1'b0; ack_in = 1'b0; done_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_req("R1 no request", 7'd0);
        bus_read(ESET, rd);  check("R1 enables", rd, 32'd0);
        bus_read(PSET, rd);  check("R1 waiting", rd, 32'd0);
        bus_read(PR0, rd);   check("R1 priority", rd, 32'd0);

        // Register table walk (R2 R3 R4)
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d table entry %0d", VECS[i].req, i), rd, VECS[i].data);
            end
        end

        // R5 line sets waiting bit and holds over clear
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        bus_read(PSET, rd); check("R5 latched after pulse", rd, 32'h8);
        @(negedge clk); irq_in[3] = 1'b1;
        bus_write(PCLR, 32'h8);
        bus_read(PSET, rd); check("R5 held line beats clear", rd, 32'h8);
        @(negedge clk); irq_in[3] = 1'b0;
        bus_write(PCLR, 32'h8);
        bus_read(PSET, rd); check("R5 cleared after release", rd, 32'h0);

        // R6 selection: line1 level 2, line2 level 1, line5 level 1
        bus_write(ESET, 32'h26);
        bus_write(PR0, 32'h0040_8000);
        bus_write(PR1, 32'h0000_4000);
        bus_write(PSET, 32'h26);
        check_req("R7 equal-or-worse blocked at exec 0", 7'd0);
        @(negedge clk); exec_prio = 3'd4;
        check_req("R6 tie goes to lower line", {1'b1, 6'd18});
        bus_write(PCLR, 32'h4);
        check_req("R6 next most urgent", {1'b1, 6'd21});
        bus_write(PCLR, 32'h20);
        check_req("R6 lone winner", {1'b1, 6'd17});

        // R7 strict comparison
        @(negedge clk); exec_prio = 3'd2;
        check_req("R7 equal level blocked", 7'd0);
        @(negedge clk); exec_prio = 3'd3;
        check_req("R7 more urgent offered", {1'b1, 6'd17});

        // R2 disabled line not offered
        bus_write(ECLR, 32'h2);
        check_req("R2 disabled not offered", 7'd0);
        bus_write(ESET, 32'h2);
        check_req("R2 re-enabled offered", {1'b1, 6'd17});

        // R8 global disable
        pulse_ctl(1'b1, 1'b0, 1'b0, 1'b0, 6'd0);
        check_req("R8 masked", 7'd0);
        pulse_ctl(1'b1, 1'b1, 1'b0, 1'b0, 6'd0);
        check_req("R8 set beats clear", 7'd0);
        pulse_ctl(1'b0, 1'b1, 1'b0, 1'b0, 6'd0);
        check_req("R8 unmasked", {1'b1, 6'd17});

        // R10 acknowledge moves to service
        @(negedge clk); exec_prio = 3'd4;
        pulse_ctl(1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
        check_req("R10 not offered in service", 7'd0);
        bus_read(PSET, rd); check("R10 waiting cleared by ack", rd, 32'h0);
        bus_write(PSET, 32'h2);
        check_req("R10 re-pended but in service", 7'd0);
        pulse_ctl(1'b0, 1'b0, 1'b0, 1'b1, 6'd17);
        check_req("R11 offered after completion", {1'b1, 6'd17});

        // R9 non-maskable line
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
        check_req("R9 beats waiting line", {1'b1, 6'd2});
        pulse_ctl(1'b1, 1'b0, 1'b0, 1'b0, 6'd0);
        @(negedge clk); exec_prio = 3'd0;
        check_req("R9 ignores mask and exec", {1'b1, 6'd2});
        pulse_ctl(1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
        check_req("R10 non-maskable in service", 7'd0);
        pulse_ctl(1'b0, 1'b0, 1'b0, 1'b1, 6'd2);
        check_req("R11 non-maskable finished, line low", 7'd0);
        pulse_ctl(1'b0, 1'b1, 1'b0, 1'b0, 6'd0);
        @(negedge clk); exec_prio = 3'd4;
        check_req("R11 ordinary line back", {1'b1, 6'd17});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule